// File: doc/BRIEF.md
# Operator Console Run-Control Sequencer

This block sits between an operator panel and a processor core and decides when the core may run. It takes raw pushbutton levels (start, stop, system reset, restart-from-PSW, check reset, set instruction address, store, display) and a rate selector, and turns each press into a single internal event. It then drives run and single-step enables, the manual (stopped) indicator, and a set of simple request lines toward the core, the storage and the error logic.

The stop button does not cut the core off mid-instruction. The sequencer waits for an instruction boundary, or acts at once when the core reports its wait state. It also lets every pending unmasked interrupt be serviced before it settles in the stopped state. Moving the rate selector to single-cycle stops a running core at once. In single-cycle mode each start press yields exactly one step pulse, and an interrupt is never run automatically.

Panel operations that touch the instruction address or storage are accepted only while the core is stopped. Storage traffic and the PSW load use a request/acknowledge pair. Any press made while such a handshake is still open is dropped, except system reset and restart, which always act.

Top module: `console_seq`

## Requirements
- R1: After a stop press while running in process mode, `run_en` stays 1 until a cycle with `cpu_eoi` or `cpu_wait` high. With neither high the core keeps running. With either high (and no pending interrupt) `manual_light` turns on on the next clock.
- R2: If `cpu_irq` is high at the boundary where a stop would complete, `run_en` stays 1. `manual_light` turns on only after a cycle with `cpu_irq_done` high and `cpu_irq` low.
- R3: A synchronized `rate_single` of 1 stops a running core at once. In single-cycle mode a start press in the stopped state gives exactly one one-cycle `step_en` pulse, and the core stays stopped.
- R4: In single-cycle mode a pending `cpu_irq` never raises `run_en`. The core only advances through `step_en`.
- R5: The first start after a system reset (or after power-up reset) pulses `start_fresh` once. A start after a normal stop does not.
- R6: System reset acts in every state. It forces the stopped state, gives one `sys_reset_req` pulse together with `iar_load` carrying value 0, and drops any open storage request.
- R7: Restart gives one `sys_reset_req` pulse, then holds `lpsw_req` with `mem_addr` = 0 and `manual_light` off until `mem_ack`. It then runs (process mode) or stops (single-cycle mode).
- R8: Set-address (`iar_load` with `addr_keys`), store and display are accepted only while `manual_light` is on. Presses made while running have no effect.
- R9: Check reset gives one `err_clear` pulse in any state when no handshake is open.
- R10: After reset `manual_light` = 1, `run_en` = 0, and all request outputs are 0. `manual_light` is on exactly in the stopped state.
- R11: A button held for many cycles produces exactly one event.
- R12: While a store, display or PSW load handshake is open, every other press except system reset and restart is ignored. The open request holds its address and data until `mem_ack`.
- R13: Store holds `mem_wr_req` with the keyed address and data until `mem_ack`. Display holds `mem_rd_req` with the keyed address and, on `mem_ack`, latches `mem_rdata` into `disp_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_single | input | 1 | Rate selector: 1 = single cycle, 0 = process |
| btn_start | input | 1 | Start pushbutton level |
| btn_stop | input | 1 | Stop pushbutton level |
| btn_sysrst | input | 1 | System reset pushbutton level |
| btn_restart | input | 1 | Reset-and-load-PSW pushbutton level |
| btn_chkrst | input | 1 | Check reset pushbutton level |
| btn_setic | input | 1 | Set instruction address pushbutton level |
| btn_store | input | 1 | Store pushbutton level |
| btn_display | input | 1 | Display pushbutton level |
| addr_keys | input | AW | Address keys |
| data_keys | input | DW | Data keys |
| cpu_eoi | input | 1 | Core is at an instruction boundary |
| cpu_wait | input | 1 | Core is in its wait state |
| cpu_irq | input | 1 | An unmasked interrupt is pending |
| cpu_irq_done | input | 1 | Core finished servicing one interrupt |
| mem_ack | input | 1 | Storage acknowledges the open request |
| mem_rdata | input | DW | Storage read data |
| run_en | output | 1 | Core may run continuously |
| step_en | output | 1 | One-cycle single-step pulse |
| manual_light | output | 1 | Stopped indicator |
| start_fresh | output | 1 | Pulse: begin at the instruction address register |
| iar_load | output | 1 | Load pulse for the instruction address register |
| iar_value | output | AW | Value to load |
| mem_wr_req | output | 1 | Storage write request |
| mem_rd_req | output | 1 | Storage read request |
| lpsw_req | output | 1 | Load-PSW request |
| mem_addr | output | AW | Storage address for the open request |
| mem_wdata | output | DW | Storage write data |
| disp_value | output | DW | Displayed data |
| sys_reset_req | output | 1 | System reset pulse |
| err_clear | output | 1 | Error register clear pulse |

## Verification
On every cycle the assertions check the following. The stop path keeps the core running while no boundary or wait is seen, and while interrupts are still draining. A step pulse never lasts two cycles and occurs only while stopped. At most one storage-type request is open at a time. An open store keeps its address and data. The display value moves only on a read acknowledge. Set-address and store start only from the manual state. The bench scenarios cover the orderings that need a sequence of presses: the fresh-start flag across a reset versus a normal stop, the full restart handshake, abort of an open store by system reset, single presses held for many cycles, and presses dropped while a handshake is open.

// File: rtl/console_pkg.sv
package console_pkg;

    typedef enum logic [2:0] {
        ST_STOPPED,
        ST_RUN,
        ST_STOP_PEND,
        ST_DRAIN,
        ST_LOADPSW
    } run_state_e;

    typedef enum logic [1:0] {
        PN_IDLE,
        PN_WRITE,
        PN_READ
    } panel_state_e;

    localparam int NUM_BTN = 8;

    // Bit order matches the packing done in the top module (start is MSB).
    typedef struct packed {
        logic start;
        logic stop;
        logic sysrst;
        logic restart;
        logic chkrst;
        logic setic;
        logic store;
        logic display;
    } btn_ev_t;

    function automatic logic is_running(run_state_e s);
        return (s == ST_RUN) || (s == ST_STOP_PEND) || (s == ST_DRAIN);
    endfunction

endpackage

// File: rtl/console_sync.sv
module console_sync #(
    parameter int N         = 8,
    parameter int STAGES    = 2,
    parameter bit EDGE_MODE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] q
);
    localparam int LAST = STAGES;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [LAST:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[LAST-1:0], raw[i]};
        end
        if (EDGE_MODE) begin : g_edge
            assign q[i] = sh[LAST-1] & ~sh[LAST];
        end else begin : g_level
            assign q[i] = sh[LAST-1];
        end
    end
endmodule

// File: rtl/console_runctl.sv
module console_runctl
    import console_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_p,
    input  logic stop_p,
    input  logic sysrst_p,
    input  logic restart_p,
    input  logic rate_single,
    input  logic cpu_eoi,
    input  logic cpu_wait,
    input  logic cpu_irq,
    input  logic cpu_irq_done,
    input  logic mem_ack,
    input  logic panel_busy,
    output logic run_en,
    output logic manual,
    output logic step_en,
    output logic start_fresh,
    output logic sys_reset_req,
    output logic lpsw_req
);
    run_state_e st, st_nx;
    logic       fresh_q;
    logic       hard;
    logic       start_ok;

    assign hard     = sysrst_p | restart_p;
    assign start_ok = start_p && !panel_busy && (st == ST_STOPPED);

    always_comb begin
        st_nx = st;
        if (sysrst_p) begin
            st_nx = ST_STOPPED;
        end else if (restart_p) begin
            st_nx = ST_LOADPSW;
        end else begin
            case (st)
                ST_STOPPED:   if (start_ok && !rate_single) st_nx = ST_RUN;
                ST_RUN: begin
                    if (rate_single) st_nx = ST_STOPPED;
                    else if (stop_p) st_nx = ST_STOP_PEND;
                end
                ST_STOP_PEND: begin
                    if (rate_single)             st_nx = ST_STOPPED;
                    else if (cpu_eoi || cpu_wait) st_nx = cpu_irq ? ST_DRAIN : ST_STOPPED;
                end
                ST_DRAIN: begin
                    if (rate_single)                   st_nx = ST_STOPPED;
                    else if (cpu_irq_done && !cpu_irq) st_nx = ST_STOPPED;
                end
                ST_LOADPSW:   if (mem_ack) st_nx = rate_single ? ST_STOPPED : ST_RUN;
                default:      st_nx = ST_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_STOPPED;
            fresh_q       <= 1'b1;
            step_en       <= 1'b0;
            start_fresh   <= 1'b0;
            sys_reset_req <= 1'b0;
        end else begin
            st            <= st_nx;
            step_en       <= !hard && start_ok && rate_single;
            start_fresh   <= !hard && start_ok && fresh_q;
            sys_reset_req <= hard;
            if (sysrst_p)       fresh_q <= 1'b1;
            else if (restart_p) fresh_q <= 1'b0;
            else if (start_ok)  fresh_q <= 1'b0;
        end
    end

    assign run_en   = is_running(st);
    assign manual   = (st == ST_STOPPED);
    assign lpsw_req = (st == ST_LOADPSW);

    // R1: no boundary and no wait state means the core keeps running
    p_stop_waits_boundary_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP_PEND && !cpu_eoi && !cpu_wait && !rate_single && !hard) |=> run_en);

    // R2: a pending interrupt at the boundary keeps the core running
    p_irq_before_stop_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP_PEND && (cpu_eoi || cpu_wait) && cpu_irq && !rate_single && !hard) |=> run_en);

    // R2: draining continues until the last interrupt is done
    p_drain_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN && !(cpu_irq_done && !cpu_irq) && !rate_single && !hard) |=> run_en);

    // R3: a step is a single-cycle pulse
    p_step_single_r3: assert property (@(posedge clk) disable iff (rst)
        step_en |=> !step_en);

    // R4: stepping only ever happens while stopped
    p_step_stopped_r4: assert property (@(posedge clk) disable iff (rst)
        step_en |-> (manual && !run_en));

    // R6: a reset pulse leaves the core stopped or loading the PSW
    p_reset_lands_r6: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> (manual || lpsw_req));
endmodule

// File: rtl/console_panel.sv
module console_panel
    import console_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hard,
    input  logic          chkrst_p,
    input  logic          setic_p,
    input  logic          store_p,
    input  logic          display_p,
    input  logic          manual,
    input  logic          loading,
    input  logic [AW-1:0] addr_keys,
    input  logic [DW-1:0] data_keys,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr_req,
    output logic          mem_rd_req,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_wdata,
    output logic [DW-1:0] disp_value,
    output logic          setic_load,
    output logic [AW-1:0] setic_value,
    output logic          err_clear,
    output logic          busy
);
    panel_state_e ps;
    logic         gate;

    assign busy = (ps != PN_IDLE);
    assign gate = manual && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ps          <= PN_IDLE;
            op_addr     <= '0;
            op_wdata    <= '0;
            disp_value  <= '0;
            setic_load  <= 1'b0;
            setic_value <= '0;
            err_clear   <= 1'b0;
        end else begin
            setic_load <= 1'b0;
            err_clear  <= 1'b0;
            if (hard) begin
                ps <= PN_IDLE;
            end else begin
                case (ps)
                    PN_IDLE: begin
                        if (gate && setic_p) begin
                            setic_load  <= 1'b1;
                            setic_value <= addr_keys;
                        end else if (gate && store_p) begin
                            ps       <= PN_WRITE;
                            op_addr  <= addr_keys;
                            op_wdata <= data_keys;
                        end else if (gate && display_p) begin
                            ps      <= PN_READ;
                            op_addr <= addr_keys;
                        end
                    end
                    PN_WRITE: if (mem_ack) ps <= PN_IDLE;
                    PN_READ: begin
                        if (mem_ack) begin
                            ps         <= PN_IDLE;
                            disp_value <= mem_rdata;
                        end
                    end
                    default: ps <= PN_IDLE;
                endcase
                if (chkrst_p && !busy && !loading) err_clear <= 1'b1;
            end
        end
    end

    assign mem_wr_req = (ps == PN_WRITE);
    assign mem_rd_req = (ps == PN_READ);

    // R8: set-address only from the manual state
    p_setic_manual_r8: assert property (@(posedge clk) disable iff (rst)
        setic_load |-> $past(manual));

    // R8: a store begins only from the manual state
    p_store_manual_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_req) |-> $past(manual));

    // R12: an open store keeps its address and data
    p_wr_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && !mem_ack && !hard) |=> (mem_wr_req && $stable(op_addr) && $stable(op_wdata)));

    // R13: the displayed value changes only on a read acknowledge
    p_disp_stable_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_req && mem_ack) |=> $stable(disp_value));
endmodule

// File: rtl/console_seq.sv
module console_seq
    import console_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rate_single,
    input  logic          btn_start,
    input  logic          btn_stop,
    input  logic          btn_sysrst,
    input  logic          btn_restart,
    input  logic          btn_chkrst,
    input  logic          btn_setic,
    input  logic          btn_store,
    input  logic          btn_display,
    input  logic [AW-1:0] addr_keys,
    input  logic [DW-1:0] data_keys,
    input  logic          cpu_eoi,
    input  logic          cpu_wait,
    input  logic          cpu_irq,
    input  logic          cpu_irq_done,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          run_en,
    output logic          step_en,
    output logic          manual_light,
    output logic          start_fresh,
    output logic          iar_load,
    output logic [AW-1:0] iar_value,
    output logic          mem_wr_req,
    output logic          mem_rd_req,
    output logic          lpsw_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] disp_value,
    output logic          sys_reset_req,
    output logic          err_clear
);
    logic [NUM_BTN-1:0] btn_raw, btn_rise;
    logic [0:0]         rate_q;
    btn_ev_t            ev;
    logic               panel_busy;
    logic               setic_load;
    logic [AW-1:0]      setic_value;
    logic [AW-1:0]      op_addr;

    assign btn_raw = {btn_start, btn_stop, btn_sysrst, btn_restart,
                      btn_chkrst, btn_setic, btn_store, btn_display};

    console_sync #(.N(NUM_BTN), .STAGES(SYNC_STAGES), .EDGE_MODE(1'b1)) u_btn_sync (
        .clk (clk), .rst (rst), .raw (btn_raw), .q (btn_rise)
    );

    console_sync #(.N(1), .STAGES(SYNC_STAGES), .EDGE_MODE(1'b0)) u_rate_sync (
        .clk (clk), .rst (rst), .raw (rate_single), .q (rate_q)
    );

    assign ev = btn_ev_t'(btn_rise);

    console_runctl u_runctl (
        .clk           (clk),
        .rst           (rst),
        .start_p       (ev.start),
        .stop_p        (ev.stop),
        .sysrst_p      (ev.sysrst),
        .restart_p     (ev.restart),
        .rate_single   (rate_q[0]),
        .cpu_eoi       (cpu_eoi),
        .cpu_wait      (cpu_wait),
        .cpu_irq       (cpu_irq),
        .cpu_irq_done  (cpu_irq_done),
        .mem_ack       (mem_ack),
        .panel_busy    (panel_busy),
        .run_en        (run_en),
        .manual        (manual_light),
        .step_en       (step_en),
        .start_fresh   (start_fresh),
        .sys_reset_req (sys_reset_req),
        .lpsw_req      (lpsw_req)
    );

    console_panel #(.AW(AW), .DW(DW)) u_panel (
        .clk         (clk),
        .rst         (rst),
        .hard        (ev.sysrst | ev.restart),
        .chkrst_p    (ev.chkrst),
        .setic_p     (ev.setic),
        .store_p     (ev.store),
        .display_p   (ev.display),
        .manual      (manual_light),
        .loading     (lpsw_req),
        .addr_keys   (addr_keys),
        .data_keys   (data_keys),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .mem_wr_req  (mem_wr_req),
        .mem_rd_req  (mem_rd_req),
        .op_addr     (op_addr),
        .op_wdata    (mem_wdata),
        .disp_value  (disp_value),
        .setic_load  (setic_load),
        .setic_value (setic_value),
        .err_clear   (err_clear),
        .busy        (panel_busy)
    );

    assign iar_load  = setic_load | sys_reset_req;
    assign iar_value = sys_reset_req ? '0 : setic_value;
    assign mem_addr  = lpsw_req ? '0 : op_addr;

    // R12: at most one storage-type handshake open at a time
    p_one_request_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_wr_req, mem_rd_req, lpsw_req}));

    // R7: the PSW load always reads address zero
    p_lpsw_addr_r7: assert property (@(posedge clk) disable iff (rst)
        lpsw_req |-> (mem_addr == '0 && !manual_light));
endmodule

// File: tb/console_seq_bench.sv
module console_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    localparam int K_START = 0, K_STOP = 1, K_SYSRST = 2, K_RESTART = 3,
                   K_CHK = 4, K_SETIC = 5, K_STORE = 6, K_DISP = 7;

    typedef struct packed {
        logic [2:0] key;
        logic       rate;
        logic       exp_run;
        logic       exp_man;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 1'b0, 1'b1, 1'b0},   // start, process: runs
        '{3'd5, 1'b0, 1'b1, 1'b0},   // set-address while running: ignored
        '{3'd1, 1'b0, 1'b0, 1'b1},   // stop at boundary
        '{3'd0, 1'b1, 1'b0, 1'b1},   // start in single cycle: stays stopped
        '{3'd0, 1'b0, 1'b1, 1'b0},   // start, process
        '{3'd2, 1'b0, 1'b0, 1'b1},   // system reset
        '{3'd0, 1'b0, 1'b1, 1'b0},   // start after reset
        '{3'd1, 1'b0, 1'b0, 1'b1}    // stop
    };

    logic clk = 1'b0, rst = 1'b1;
    logic rate_single = 0, btn_start = 0, btn_stop = 0, btn_sysrst = 0, btn_restart = 0;
    logic btn_chkrst = 0, btn_setic = 0, btn_store = 0, btn_display = 0;
    logic [AW-1:0] addr_keys = '0;
    logic [DW-1:0] data_keys = '0, mem_rdata = '0;
    logic cpu_eoi = 1, cpu_wait = 0, cpu_irq = 0, cpu_irq_done = 0, mem_ack = 0;
    logic run_en, step_en, manual_light, start_fresh, iar_load, mem_wr_req, mem_rd_req;
    logic lpsw_req, sys_reset_req, err_clear;
    logic [AW-1:0] iar_value, mem_addr;
    logic [DW-1:0] mem_wdata, disp_value;

    int checks = 0, fails = 0;
    int step_cnt = 0, rst_cnt = 0, fresh_cnt = 0, iar_cnt = 0, err_cnt = 0;
    logic [AW-1:0] last_iar = '1;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    console_seq #(.AW(AW), .DW(DW)) u_console_seq (
        .clk(clk), .rst(rst), .rate_single(rate_single),
        .btn_start(btn_start), .btn_stop(btn_stop), .btn_sysrst(btn_sysrst),
        .btn_restart(btn_restart), .btn_chkrst(btn_chkrst), .btn_setic(btn_setic),
        .btn_store(btn_store), .btn_display(btn_display),
        .addr_keys(addr_keys), .data_keys(data_keys),
        .cpu_eoi(cpu_eoi), .cpu_wait(cpu_wait), .cpu_irq(cpu_irq),
        .cpu_irq_done(cpu_irq_done), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .run_en(run_en), .step_en(step_en), .manual_light(manual_light),
        .start_fresh(start_fresh), .iar_load(iar_load), .iar_value(iar_value),
        .mem_wr_req(mem_wr_req), .mem_rd_req(mem_rd_req), .lpsw_req(lpsw_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .disp_value(disp_value),
        .sys_reset_req(sys_reset_req), .err_clear(err_clear)
    );

    // Pulse monitors sample on the falling edge, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (step_en)       step_cnt++;
            if (sys_reset_req) rst_cnt++;
            if (start_fresh)   fresh_cnt++;
            if (err_clear)     err_cnt++;
            if (iar_load) begin
                iar_cnt++;
                last_iar = iar_value;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_key(input int k, input logic v);
        case (k)
            K_START:   btn_start   = v;
            K_STOP:    btn_stop    = v;
            K_SYSRST:  btn_sysrst  = v;
            K_RESTART: btn_restart = v;
            K_CHK:     btn_chkrst  = v;
            K_SETIC:   btn_setic   = v;
            K_STORE:   btn_store   = v;
            default:   btn_display = v;
        endcase
    endtask

    task automatic press(input int k);
        @(negedge clk);
        set_key(k, 1'b1);
        cyc(2);
        set_key(k, 1'b0);
        cyc(5);
    endtask

    task automatic ack();
        @(negedge clk);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        cyc(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0, c0;
        cyc(4);
        rst = 1'b0;
        cyc(2);
        // R10: reset state
        chk("R10", "manual after reset", manual_light, 1);
        chk("R10", "run after reset", run_en, 0);
        chk("R10", "requests after reset", {mem_wr_req, mem_rd_req, lpsw_req, step_en}, 0);

        // Table walk: presses with the core always at a boundary
        for (int i = 0; i < NVEC; i++) begin
            rate_single = VEC[i].rate;
            cyc(4);
            press(int'(VEC[i].key));
            chk("R3", $sformatf("vec %0d run", i), run_en, VEC[i].exp_run);
            chk("R10", $sformatf("vec %0d manual", i), manual_light, VEC[i].exp_man);
        end
        chk("R8", "set-address while running ignored", iar_cnt, 1);  // only the reset load
        chk("R3", "one step from table", step_cnt, 1);

        // R1: stop waits for boundary
        cpu_eoi = 0;
        press(K_START);
        press(K_STOP);
        cyc(10);
        chk("R1", "running without boundary", run_en, 1);
        cpu_eoi = 1;
        cyc(2);
        chk("R1", "stopped at boundary", manual_light, 1);
        cpu_eoi = 0;
        press(K_START);
        cpu_wait = 1;
        press(K_STOP);
        chk("R1", "wait state stops at once", manual_light, 1);
        cpu_wait = 0;

        // R2: interrupts drained before stopping
        press(K_START);
        cpu_irq = 1;
        press(K_STOP);
        cpu_eoi = 1;
        cyc(3);
        chk("R2", "running while irq pending", run_en, 1);
        cpu_irq_done = 1; cyc(1); cpu_irq_done = 0;
        cyc(2);
        chk("R2", "still running, irq remains", run_en, 1);
        cpu_irq = 0;
        cpu_irq_done = 1; cyc(1); cpu_irq_done = 0;
        cyc(1);
        chk("R2", "stopped after drain", manual_light, 1);

        // R3: rate switch stops a running core
        press(K_START);
        rate_single = 1;
        cyc(4);
        chk("R3", "rate switch stops", manual_light, 1);

        // R4: single cycle with a pending interrupt
        cpu_irq = 1;
        s0 = step_cnt;
        press(K_START);
        chk("R4", "no run with irq in single", run_en, 0);
        chk("R4", "one step per press", step_cnt, s0 + 1);
        cpu_irq = 0;
        rate_single = 0;
        cyc(4);

        // R5: fresh start only after reset
        c0 = fresh_cnt;
        press(K_START);
        press(K_STOP);
        chk("R5", "no fresh after normal stop", fresh_cnt, c0);
        press(K_SYSRST);
        press(K_START);
        chk("R5", "fresh after reset", fresh_cnt, c0 + 1);
        press(K_STOP);

        // R7: restart sequence
        c0 = rst_cnt;
        press(K_RESTART);
        chk("R7", "reset pulse", rst_cnt, c0 + 1);
        chk("R7", "load request", lpsw_req, 1);
        chk("R7", "load address", mem_addr, 0);
        chk("R7", "light off while loading", manual_light, 0);
        ack();
        chk("R7", "runs after load", run_en, 1);
        press(K_STOP);

        // R8 / R13: set-address, store, display
        addr_keys = 16'h1234;
        press(K_SETIC);
        chk("R8", "set-address value", last_iar, 16'h1234);
        addr_keys = 16'h0040; data_keys = 32'hCAFE_0001;
        press(K_STORE);
        chk("R13", "write request", mem_wr_req, 1);
        chk("R13", "write addr/data", {mem_addr, mem_wdata}, {16'h0040, 32'hCAFE_0001});
        // R12: presses ignored while store is open
        c0 = iar_cnt;
        addr_keys = 16'h0077; data_keys = 32'h0;
        press(K_SETIC);
        press(K_DISP);
        press(K_START);
        chk("R12", "set-address ignored when busy", iar_cnt, c0);
        chk("R12", "display ignored when busy", mem_rd_req, 0);
        chk("R12", "start ignored when busy", run_en, 0);
        chk("R12", "store holds addr", mem_addr, 16'h0040);
        ack();
        chk("R13", "write closed", mem_wr_req, 0);
        addr_keys = 16'h0088;
        press(K_DISP);
        chk("R13", "read request", {mem_rd_req, mem_addr}, {1'b1, 16'h0088});
        mem_rdata = 32'h5A5A_1111;
        ack();
        chk("R13", "display latched", disp_value, 32'h5A5A_1111);

        // R9: check reset
        c0 = err_cnt;
        press(K_CHK);
        chk("R9", "error clear pulse", err_cnt, c0 + 1);

        // R11: held button gives one event
        c0 = iar_cnt;
        @(negedge clk); btn_setic = 1; cyc(20); btn_setic = 0; cyc(5);
        chk("R11", "held button one event", iar_cnt, c0 + 1);

        // R8: store while running ignored
        press(K_START);
        press(K_STORE);
        chk("R8", "store while running ignored", mem_wr_req, 0);
        press(K_STOP);

        // R6: system reset aborts an open store and clears the address
        press(K_STORE);
        press(K_SYSRST);
        chk("R6", "store dropped", mem_wr_req, 0);
        chk("R6", "stopped after reset", manual_light, 1);
        chk("R6", "address cleared", last_iar, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule